// File: doc/BRIEF.md
# SHA-256 Iterative Compression Engine

This block performs the SHA-256 compression of one 512-bit message block. It keeps eight 32-bit working words and runs one round per clock cycle for 64 rounds. A 64-entry table of round constants is built in. The expanded message schedule is generated outside the block. The engine shows which round is running on `round_o`, and the surrounding logic must present the matching schedule word on `w_i` in that same cycle.

A block starts with a one-cycle `start_i` pulse while the engine is idle. With `init_i` high, the chaining value is the standard SHA-256 initial hash. With `init_i` low, the chaining value is taken from `chain_i`. To hash a message of several blocks, the caller feeds `digest_o` back into `chain_i` and starts the next block with `init_i` low.

After the last round, each working word is added modulo 2^32 to the matching chaining word. The result is registered on `digest_o`, and `done_o` pulses for one cycle. Padding and message expansion belong to neighbouring blocks.

Top module: `sha256_round_engine`

## Requirements
- R1: While reset is held and after it is released, with no start given, `busy_o` and `done_o` are 0 and `digest_o` is all zeros.
- R2: A start with `init_i`=1 uses the standard initial hash words 6a09e667, bb67ae85, 3c6ef372, a54ff53a, 510e527f, 9b05688c, 1f83d9ab, 5be0cd19 and ignores `chain_i`. The padded one-block message "abc" gives ba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad.
- R3: A start with `init_i`=0 uses `chain_i` as the chaining value, with the first word in bits [255:224]. Chaining the two padded blocks of the 56-byte message "abcdbcde...nopq" gives 248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1.
- R4: Count the clock edge that accepts a start as edge 0. In the cycle after edge n, for n = 0 to 63, `round_o` equals n, and `w_i` is consumed as schedule word n at edge n+1.
- R5: `busy_o` is 1 from after edge 0 until edge 65. `done_o` is 1 only in the cycle after edge 65, as a single-cycle pulse.
- R6: The digest is the chaining value plus the final working words, word by word modulo 2^32. H1 sits in bits [255:224] and H8 in bits [31:0].
- R7: A start asserted while `busy_o` is 1 is ignored. The running block, its timing and its digest are unaffected.
- R8: `digest_o` changes only at the edge that raises `done_o`. Between done pulses it holds its value.
- R9: Each round applies T1 = h + Σ1(e) + Ch(e,f,g) + K + W and T2 = Σ0(a) + Maj(a,b,c). Σ0 rotates right by 2, 13 and 22, and Σ1 rotates right by 6, 11 and 25. The words then shift one place, with e receiving d+T1 and a receiving T1+T2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a block (accepted only when idle) |
| init_i | input | 1 | 1: use the standard initial hash; 0: use chain_i |
| chain_i | input | 256 | External chaining value, H1 in the top word |
| w_i | input | 32 | Schedule word for the round shown on round_o |
| round_o | output | 6 | Index of the round being computed |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle pulse when digest_o is updated |
| digest_o | output | 256 | Result of the last block, H1 in the top word |

## Verification
Every result has a fixed position relative to the edge that accepts a start. `round_o` shows n in the cycle after edge n. `busy_o` is high through the cycle after edge 64. `done_o` and the new `digest_o` appear in the cycle after edge 65. The bench drives inputs on falling edges and compares every output against a behavioural model on each falling edge for 70 cycles per block, so any result that arrives a cycle early or late is caught. Known-answer digests check the round constants and the round algebra independently of the model.

// File: rtl/sha256_eng_pkg.sv
package sha256_eng_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_WORDS  = 8;
  localparam int NUM_ROUNDS = 64;
  localparam int CNT_W      = $clog2(NUM_ROUNDS);
  localparam int DIGEST_W   = WORD_W * NUM_WORDS;

  typedef logic [WORD_W-1:0] word_t;

  // a occupies the top word so the packed state lines up with the digest order
  typedef struct packed {
    word_t a; word_t b; word_t c; word_t d;
    word_t e; word_t f; word_t g; word_t h;
  } wstate_t;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FOLD} phase_t;

  localparam logic [DIGEST_W-1:0] START_HASH = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t round_const(input logic [CNT_W-1:0] idx);
    word_t k;
    case (idx)
      6'd0:  k = 32'h428a2f98; 6'd1:  k = 32'h71374491; 6'd2:  k = 32'hb5c0fbcf; 6'd3:  k = 32'he9b5dba5;
      6'd4:  k = 32'h3956c25b; 6'd5:  k = 32'h59f111f1; 6'd6:  k = 32'h923f82a4; 6'd7:  k = 32'hab1c5ed5;
      6'd8:  k = 32'hd807aa98; 6'd9:  k = 32'h12835b01; 6'd10: k = 32'h243185be; 6'd11: k = 32'h550c7dc3;
      6'd12: k = 32'h72be5d74; 6'd13: k = 32'h80deb1fe; 6'd14: k = 32'h9bdc06a7; 6'd15: k = 32'hc19bf174;
      6'd16: k = 32'he49b69c1; 6'd17: k = 32'hefbe4786; 6'd18: k = 32'h0fc19dc6; 6'd19: k = 32'h240ca1cc;
      6'd20: k = 32'h2de92c6f; 6'd21: k = 32'h4a7484aa; 6'd22: k = 32'h5cb0a9dc; 6'd23: k = 32'h76f988da;
      6'd24: k = 32'h983e5152; 6'd25: k = 32'ha831c66d; 6'd26: k = 32'hb00327c8; 6'd27: k = 32'hbf597fc7;
      6'd28: k = 32'hc6e00bf3; 6'd29: k = 32'hd5a79147; 6'd30: k = 32'h06ca6351; 6'd31: k = 32'h14292967;
      6'd32: k = 32'h27b70a85; 6'd33: k = 32'h2e1b2138; 6'd34: k = 32'h4d2c6dfc; 6'd35: k = 32'h53380d13;
      6'd36: k = 32'h650a7354; 6'd37: k = 32'h766a0abb; 6'd38: k = 32'h81c2c92e; 6'd39: k = 32'h92722c85;
      6'd40: k = 32'ha2bfe8a1; 6'd41: k = 32'ha81a664b; 6'd42: k = 32'hc24b8b70; 6'd43: k = 32'hc76c51a3;
      6'd44: k = 32'hd192e819; 6'd45: k = 32'hd6990624; 6'd46: k = 32'hf40e3585; 6'd47: k = 32'h106aa070;
      6'd48: k = 32'h19a4c116; 6'd49: k = 32'h1e376c08; 6'd50: k = 32'h2748774c; 6'd51: k = 32'h34b0bcb5;
      6'd52: k = 32'h391c0cb3; 6'd53: k = 32'h4ed8aa4a; 6'd54: k = 32'h5b9cca4f; 6'd55: k = 32'h682e6ff3;
      6'd56: k = 32'h748f82ee; 6'd57: k = 32'h78a5636f; 6'd58: k = 32'h84c87814; 6'd59: k = 32'h8cc70208;
      6'd60: k = 32'h90befffa; 6'd61: k = 32'ha4506ceb; 6'd62: k = 32'hbef9a3f7; default: k = 32'hc67178f2;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/sha256_rst_sync.sv
module sha256_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/sha256_kconst_rom.sv
module sha256_kconst_rom
  import sha256_eng_pkg::*;
(
  input  logic [CNT_W-1:0] idx_i,
  output word_t            k_o
);
  always_comb k_o = round_const(idx_i);
endmodule

// File: rtl/sha256_round_logic.sv
module sha256_round_logic
  import sha256_eng_pkg::*;
(
  input  wstate_t cur_i,
  input  word_t   k_i,
  input  word_t   w_i,
  output wstate_t nxt_o
);
  word_t sum_e, sum_a, choose, major, t1, t2;

  always_comb begin
    sum_e  = rotr(cur_i.e, 6) ^ rotr(cur_i.e, 11) ^ rotr(cur_i.e, 25);
    sum_a  = rotr(cur_i.a, 2) ^ rotr(cur_i.a, 13) ^ rotr(cur_i.a, 22);
    choose = (cur_i.e & cur_i.f) ^ (~cur_i.e & cur_i.g);
    major  = (cur_i.a & cur_i.b) ^ (cur_i.a & cur_i.c) ^ (cur_i.b & cur_i.c);
    t1     = cur_i.h + sum_e + choose + k_i + w_i;
    t2     = sum_a + major;
    nxt_o.h = cur_i.g;
    nxt_o.g = cur_i.f;
    nxt_o.f = cur_i.e;
    nxt_o.e = cur_i.d + t1;
    nxt_o.d = cur_i.c;
    nxt_o.c = cur_i.b;
    nxt_o.b = cur_i.a;
    nxt_o.a = t1 + t2;
  end
endmodule

// File: rtl/sha256_round_ctrl.sv
module sha256_round_ctrl
  import sha256_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic             fold_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] round_o
);
  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(NUM_ROUNDS - 1);

  phase_t            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin phase_d = PH_RUN; cnt_d = '0; end
      PH_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_RND) phase_d = PH_FOLD;
      end
      PH_FOLD: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign load_o  = (phase_q == PH_IDLE) && start_i;
  assign step_o  = (phase_q == PH_RUN);
  assign fold_o  = (phase_q == PH_FOLD);
  assign busy_o  = (phase_q != PH_IDLE);
  assign round_o = cnt_q;

  // R4: rounds advance by exactly one per clock while running
  assert_round_step_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (step_o && round_o != LAST_RND) |=> (step_o && round_o == $past(round_o) + 1'b1));
  // R4: a load always begins at round zero
  assert_load_round0_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    load_o |=> (step_o && round_o == '0));
  // R7: no new block is accepted while one is in flight
  assert_no_reload_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    busy_o |-> !load_o);
  // R5: folding follows the last round and lasts one cycle
  assert_fold_after_last_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    fold_o |=> !busy_o);
endmodule

// File: rtl/sha256_round_engine.sv
module sha256_round_engine
  import sha256_eng_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                init_i,
  input  logic [DIGEST_W-1:0] chain_i,
  input  logic [WORD_W-1:0]   w_i,
  output logic [CNT_W-1:0]    round_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [DIGEST_W-1:0] digest_o
);
  logic rst_sn, load, step, fold;
  word_t k_word;
  wstate_t work_q, work_d, rnd_nxt;
  logic [DIGEST_W-1:0] base_q, base_d, fold_sum, digest_q, digest_d;
  logic done_q, done_d;

  sha256_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  sha256_round_ctrl u_ctrl (
    .clk(clk), .rst_sn(rst_sn), .start_i(start_i),
    .load_o(load), .step_o(step), .fold_o(fold),
    .busy_o(busy_o), .round_o(round_o));

  sha256_kconst_rom u_rom (.idx_i(round_o), .k_o(k_word));

  sha256_round_logic u_round (.cur_i(work_q), .k_i(k_word), .w_i(w_i), .nxt_o(rnd_nxt));

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_fold
    assign fold_sum[i*WORD_W +: WORD_W] =
      work_q[i*WORD_W +: WORD_W] + base_q[i*WORD_W +: WORD_W];
  end

  always_comb begin
    work_d   = work_q;
    base_d   = base_q;
    digest_d = digest_q;
    done_d   = 1'b0;
    if (load) begin
      base_d = init_i ? START_HASH : chain_i;
      work_d = init_i ? START_HASH : chain_i;
    end else if (step) begin
      work_d = rnd_nxt;
    end
    if (fold) begin
      digest_d = fold_sum;
      done_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      work_q   <= '0;
      base_q   <= '0;
      digest_q <= '0;
      done_q   <= 1'b0;
    end else begin
      work_q   <= work_d;
      base_q   <= base_d;
      digest_q <= digest_d;
      done_q   <= done_d;
    end
  end

  assign digest_o = digest_q;
  assign done_o   = done_q;

  // R2: init selects the built-in starting hash
  assert_load_iv_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (load && init_i) |=> (work_q == START_HASH));
  // R3: without init the external chaining value is taken
  assert_load_ext_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (load && !init_i) |=> (work_q == $past(chain_i)));
  // R9: the untouched words move down one place per round
  assert_word_shift_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    step |=> (work_q.b == $past(work_q.a) && work_q.c == $past(work_q.b) &&
              work_q.f == $past(work_q.e) && work_q.h == $past(work_q.g)));
  // R5: done is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |=> !done_o);
  // R8: the digest changes only when done rises
  assert_digest_hold_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    !fold |=> $stable(digest_o));
  // R6: top word of the digest is a plus the chained H1
  assert_fold_h1_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    fold |=> (digest_o[DIGEST_W-1 -: WORD_W] == $past(work_q.a + base_q[DIGEST_W-1 -: WORD_W])));
endmodule

// File: tb/sha256_round_engine_test.sv
`timescale 1ns/1ps
module sha256_round_engine_test;
  import sha256_eng_pkg::round_const;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i, init_i;
  logic [255:0] chain_i;
  logic [31:0]  w_i;
  logic [5:0]   round_o;
  logic         busy_o, done_o;
  logic [255:0] digest_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] wq [64];

  always #4 clk = ~clk;

  sha256_round_engine uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .init_i(init_i),
    .chain_i(chain_i), .w_i(w_i), .round_o(round_o), .busy_o(busy_o),
    .done_o(done_o), .digest_o(digest_o));

  always_comb w_i = wq[round_o];

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prep_sched(input logic [511:0] blk);
    for (int j = 0; j < 64; j++) begin
      if (j < 16) wq[j] = blk[511 - 32*j -: 32];
      else wq[j] = (rr(wq[j-2], 17) ^ rr(wq[j-2], 19) ^ (wq[j-2] >> 10)) + wq[j-7] +
                   (rr(wq[j-15], 7) ^ rr(wq[j-15], 18) ^ (wq[j-15] >> 3)) + wq[j-16];
    end
  endtask

  function automatic logic [255:0] model(input logic [255:0] chain);
    logic [31:0] v[8];
    logic [31:0] t1, t2;
    logic [255:0] r;
    for (int i = 0; i < 8; i++) v[i] = chain[255 - 32*i -: 32];
    for (int n = 0; n < 64; n++) begin
      t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25)) +
           ((v[4] & v[5]) ^ (~v[4] & v[6])) + round_const(6'(n)) + wq[n];
      t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22)) +
           ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      for (int i = 7; i > 0; i--) v[i] = v[i-1];
      v[4] = v[4] + t1;
      v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) r[255 - 32*i -: 32] = v[i] + chain[255 - 32*i -: 32];
    return r;
  endfunction

  localparam logic [255:0] IV = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  // Starts one block at a falling edge and compares every output each cycle.
  task automatic run_block(input logic init, input logic [255:0] chain, input logic [511:0] blk,
                           input bit poke, input string req, output logic [255:0] dig);
    logic [255:0] exp, prev;
    prep_sched(blk);
    exp  = model(init ? IV : chain);
    prev = digest_o;
    @(negedge clk);
    start_i = 1'b1; init_i = init;
    chain_i = init ? {8{32'hdeadbeef}} : chain;   // R2: chain_i is ignored under init
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 1; k <= 70; k++) begin
      if (k > 1) @(negedge clk);
      chk(busy_o == (k <= 65), "R5 busy", 256'(busy_o), 256'(k <= 65));
      chk(done_o == (k == 66), "R5 done", 256'(done_o), 256'(k == 66));
      if (k <= 64) chk(round_o == 6'(k - 1), "R4 round index", 256'(round_o), 256'(k - 1));
      if (k == 66) begin
        chk(digest_o == exp, {req, " R6 R9 digest"}, digest_o, exp);
        dig = digest_o;
      end else if (k < 66) chk(digest_o == prev, "R8 digest hold", digest_o, prev);
      else chk(digest_o == exp, "R8 digest hold", digest_o, exp);
      if (poke && k == 10) begin        // R7: start while busy, different mode and chain
        start_i = 1'b1; init_i = ~init; chain_i = ~chain;
      end else start_i = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] d1, d2, d3;
    logic [511:0] blk;
    rst_n = 1'b0; start_i = 1'b0; init_i = 1'b0; chain_i = '0;
    for (int j = 0; j < 64; j++) wq[j] = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && digest_o == '0, "R1 during reset", {busy_o, done_o, digest_o[253:0]}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && digest_o == '0, "R1 after reset", {busy_o, done_o, digest_o[253:0]}, '0);

    // R2: "abc" known answer
    blk = '0; blk[511:480] = 32'h61626380; blk[31:0] = 32'h18;
    run_block(1'b1, '0, blk, 1'b0, "R2", d1);
    chk(d1 == 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad,
        "R2 abc known answer", d1, 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);

    // R3: two chained blocks, with a start poked mid-block (R7)
    blk = {32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667, 32'h65666768, 32'h66676869,
           32'h6768696a, 32'h68696a6b, 32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
           32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
    run_block(1'b1, '0, blk, 1'b1, "R7", d2);
    blk = '0; blk[31:0] = 32'h1c0;
    run_block(1'b0, d2, blk, 1'b1, "R3", d3);
    chk(d3 == 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1,
        "R3 two-block known answer", d3, 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1);

    // R3: arbitrary chaining value and block
    for (int i = 0; i < 16; i++) blk[i*32 +: 32] = $urandom;
    for (int i = 0; i < 8; i++) d1[i*32 +: 32] = $urandom;
    run_block(1'b0, d1, blk, 1'b0, "R3 random", d2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule